// File: doc/BRIEF.md
# Cascaded Bus Rate Divider

This block derives three bus rates from one system clock without creating any new clock. Each rate is a strobe that is high for exactly one system-clock cycle. Logic on that bus advances only in cycles where its strobe is high. One stage divides the system clock to give the fast bus rate. Two peripheral stages then divide the fast-bus strobe further, so a peripheral rate is always the fast-bus ratio multiplied by its own ratio.

The ratios come from a 32-bit configuration word. The word is loaded through a single-cycle write port and is always visible on a read port. Only three fields of the word are implemented. A ratio written while the block is running is applied at the next strobe of the affected stage. The period in progress therefore completes with the old ratio.

Top module: `busrate_divtree`

## Requirements
- R1: After reset the read port returns 0x00000000, and all three strobes are high in every system-clock cycle (every stage divides by 1).
- R2: The fast-bus field is bits 7:4. Codes 1000, 1001, 1010, 1011, 1100, 1101, 1110 and 1111 give ratios 2, 4, 8, 16, 64, 128, 256 and 512. No code gives a ratio of 32. Any code with bit 7 at 0 gives a ratio of 1.
- R3: The first peripheral field is bits 12:10 and the second is bits 15:13. In each, codes 100, 101, 110 and 111 give ratios 2, 4, 8 and 16, and any code with its top bit at 0 gives a ratio of 1.
- R4: Each strobe is high for one system-clock cycle once every N input ticks, where N is the stage ratio. A stage at ratio 1 repeats its input ticks unchanged, in the same cycle.
- R5: Both peripheral stages count fast-bus strobes, not system-clock cycles. A peripheral strobe only occurs in a cycle where the fast-bus strobe is high, and its spacing in system cycles is the fast-bus ratio times the peripheral ratio.
- R6: A ratio written while a stage is counting takes effect after that stage's next strobe. The period in progress keeps the old ratio, and every later period uses the new ratio.
- R7: Bits outside 15:10 and 7:4 always read back as 0. Writing to them has no effect on the read value or on any strobe.
- R8: A write stores the three field values, and they appear on the read port from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Stored configuration word, with unimplemented bits at 0 |
| hs_tick | output | 1 | Fast-bus enable strobe |
| pa_tick | output | 1 | First peripheral enable strobe |
| pb_tick | output | 1 | Second peripheral enable strobe |

## Verification
The assertions check four properties on every cycle:
- No strobe occurs without an input tick, and no peripheral strobe occurs outside a fast-bus strobe.
- Each counter stays within its current ratio.
- A stage switches ratio only at one of its own strobes.
- Writes reach the read port one cycle later, and the stored word holds at all other times.

The exact spacing of each code, the missing ratio of 32, the ratio products of the cascade, and the length of the period that spans a runtime change can only be shown by the bench. It measures these by comparing against its behavioural model on every clock and by timing the intervals between strobes.

// File: rtl/busrate_pkg.sv
package busrate_pkg;

  localparam int CFG_W     = 32;
  localparam int HS_LSB    = 4;
  localparam int HS_W      = 4;
  localparam int PA_LSB    = 10;
  localparam int PB_LSB    = 13;
  localparam int PER_W     = 3;
  localparam int HS_MAXSH  = 9;   // log2 of largest fast-bus ratio
  localparam int PER_MAXSH = 4;   // log2 of largest peripheral ratio
  localparam int HS_SH_W   = $clog2(HS_MAXSH + 1);
  localparam int PER_SH_W  = $clog2(PER_MAXSH + 1);

  localparam logic [CFG_W-1:0] CFG_MASK =
      (CFG_W'((1 << HS_W) - 1) << HS_LSB) |
      (CFG_W'((1 << PER_W) - 1) << PA_LSB) |
      (CFG_W'((1 << PER_W) - 1) << PB_LSB);

  // Fast-bus code -> log2(ratio); the 32 step is skipped in the upper half.
  function automatic logic [HS_SH_W-1:0] hs_shift(input logic [HS_W-1:0] code);
    logic [HS_SH_W-1:0] low;
    low = HS_SH_W'(code[1:0]);
    if (!code[3])     return '0;
    else if (!code[2]) return low + HS_SH_W'(1);
    else               return low + HS_SH_W'(6);
  endfunction

  // Peripheral code -> log2(ratio).
  function automatic logic [PER_SH_W-1:0] per_shift(input logic [PER_W-1:0] code);
    if (!code[2]) return '0;
    else          return PER_SH_W'(code[1:0]) + PER_SH_W'(1);
  endfunction

endpackage

// File: rtl/busrate_cfgreg.sv
module busrate_cfgreg
  import busrate_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [CFG_W-1:0]    wdata,
  output logic [CFG_W-1:0]    rdata,
  output logic [HS_SH_W-1:0]  hs_sh,
  output logic [PER_SH_W-1:0] pa_sh,
  output logic [PER_SH_W-1:0] pb_sh
);

  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= '0;
    else if (we) word_q <= wdata & CFG_MASK;
  end

  assign rdata = word_q;
  assign hs_sh = hs_shift(word_q[HS_LSB +: HS_W]);
  assign pa_sh = per_shift(word_q[PA_LSB +: PER_W]);
  assign pb_sh = per_shift(word_q[PB_LSB +: PER_W]);

  // R8: a write appears on the read port one cycle later
  a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == ($past(wdata) & CFG_MASK)));

  // R7: without a write the stored word does not move
  a_r7_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata));

endmodule

// File: rtl/busrate_stage.sv
module busrate_stage #(
  parameter int MAX_SHIFT = 9,
  parameter int SH_W      = $clog2(MAX_SHIFT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_tick,
  input  logic [SH_W-1:0] req_shift,
  output logic            out_tick
);

  localparam int CNT_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [SH_W-1:0]  active_sh;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [CNT_W:0]   pow;
  logic             at_end;

  assign pow      = (CNT_W+1)'(1) << active_sh;
  assign lim      = CNT_W'(pow - (CNT_W+1)'(1));
  assign at_end   = (cnt == lim);
  assign out_tick = in_tick & at_end;

  // The requested ratio is taken only when a period closes (R6).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      active_sh <= '0;
    end else if (in_tick) begin
      if (at_end) begin
        cnt       <= '0;
        active_sh <= req_shift;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  // R4: a strobe can only come from an input tick
  a_r4_strobe_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> in_tick);

  // R4: the count never runs past the current ratio
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= lim);

  // R6: the active ratio changes only right after a strobe
  a_r6_switch_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_sh) |-> $past(out_tick));

  // R2: the applied shift never exceeds the largest legal ratio
  a_r2_shift_legal: assert property (@(posedge clk) disable iff (!rst_n)
    active_sh <= SH_W'(MAX_SHIFT));

endmodule

// File: rtl/busrate_divtree.sv
module busrate_divtree
  import busrate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             hs_tick,
  output logic             pa_tick,
  output logic             pb_tick
);

  localparam int N_PER = 2;

  logic [HS_SH_W-1:0]  hs_sh;
  logic [PER_SH_W-1:0] per_sh [N_PER];
  logic [N_PER-1:0]    per_tick;

  busrate_cfgreg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .hs_sh (hs_sh),
    .pa_sh (per_sh[0]),
    .pb_sh (per_sh[1])
  );

  busrate_stage #(.MAX_SHIFT(HS_MAXSH), .SH_W(HS_SH_W)) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_tick   (1'b1),
    .req_shift (hs_sh),
    .out_tick  (hs_tick)
  );

  // Peripheral stages are fed by the fast-bus strobe (R5).
  for (genvar g = 0; g < N_PER; g++) begin : g_per
    busrate_stage #(.MAX_SHIFT(PER_MAXSH), .SH_W(PER_SH_W)) u_per (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_tick   (hs_tick),
      .req_shift (per_sh[g]),
      .out_tick  (per_tick[g])
    );
  end

  assign pa_tick = per_tick[0];
  assign pb_tick = per_tick[1];

  // R5: peripheral strobes sit inside fast-bus strobes
  a_r5_pa_inside_hs: assert property (@(posedge clk) disable iff (!rst_n)
    pa_tick |-> hs_tick);
  a_r5_pb_inside_hs: assert property (@(posedge clk) disable iff (!rst_n)
    pb_tick |-> hs_tick);

endmodule

// File: tb/busrate_divtree_tb_top.sv
`timescale 1ns/1ps
module busrate_divtree_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        hs_tick, pa_tick, pb_tick;

  int checks = 0;
  int fails  = 0;
  bit model_on = 0;
  bit done = 0;

  always #10 clk = ~clk;

  busrate_divtree dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hs_tick(hs_tick), .pa_tick(pa_tick), .pb_tick(pb_tick)
  );

  function automatic int hs_div(input int code);
    case (code)
      8: return 2;    9: return 4;    10: return 8;   11: return 16;
      12: return 64;  13: return 128; 14: return 256; 15: return 512;
      default: return 1;
    endcase
  endfunction

  function automatic int per_div(input int code);
    case (code)
      4: return 2; 5: return 4; 6: return 8; 7: return 16;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference: ratio held per stage, count of input ticks.
  logic [31:0] m_cfg = '0;
  int m_ratio [3] = '{1, 1, 1};
  int m_cnt   [3] = '{0, 0, 0};
  longint cyc = 0;
  longint last_t [3] = '{0, 0, 0};
  longint intv   [3] = '{0, 0, 0};
  int     nt     [3] = '{0, 0, 0};

  always @(negedge clk) begin
    if (model_on) begin
      bit ein [3];
      bit eout [3];
      bit got [3];
      int req [3];
      got[0] = hs_tick; got[1] = pa_tick; got[2] = pb_tick;
      req[0] = hs_div(int'(m_cfg[7:4]));
      req[1] = per_div(int'(m_cfg[12:10]));
      req[2] = per_div(int'(m_cfg[15:13]));
      ein[0] = 1'b1;
      eout[0] = (m_cnt[0] == m_ratio[0] - 1);
      for (int k = 1; k < 3; k++) begin
        ein[k]  = eout[0];
        eout[k] = ein[k] && (m_cnt[k] == m_ratio[k] - 1);
      end
      // R4 R5 R6: every strobe matches the model in every cycle
      chk("R4/R5/R6 hs strobe", got[0], eout[0]);
      chk("R4/R5/R6 pa strobe", got[1], eout[1]);
      chk("R4/R5/R6 pb strobe", got[2], eout[2]);
      for (int k = 0; k < 3; k++) begin
        if (ein[k]) begin
          if (eout[k]) begin m_cnt[k] = 0; m_ratio[k] = req[k]; end
          else m_cnt[k]++;
        end
        if (got[k]) begin
          intv[k] = cyc - last_t[k];
          last_t[k] = cyc;
          nt[k]++;
        end
      end
      if (cfg_we) m_cfg = cfg_wdata & 32'h0000_FCF0;
      cyc++;
    end
  end

  task automatic wr(input logic [31:0] v);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic wait_ticks(input int k, input int n);
    int start;
    int guard;
    start = nt[k];
    guard = 0;
    while (nt[k] < start + n) begin
      @(posedge clk);
      guard++;
      if (guard > 30000) begin
        chk("watchdog wait_ticks", guard, 0);
        return;
      end
    end
  endtask

  // Apply a setting, let it settle, and measure strobe spacing.
  task automatic measure(input logic [31:0] v, input string req);
    int h, a, b;
    h = hs_div(int'(v[7:4]));
    a = per_div(int'(v[12:10]));
    b = per_div(int'(v[15:13]));
    wr(v);
    wait_ticks(0, 3); chk({req, " hs spacing"}, intv[0], h);
    wait_ticks(1, 3); chk({req, " pa spacing"}, intv[1], h * a);
    wait_ticks(2, 3); chk({req, " pb spacing"}, intv[2], h * b);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset rdata", cfg_rdata, 0);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1: immediately after reset every stage divides by 1
    chk("R1 hs after reset", hs_tick, 1);
    chk("R1 pa after reset", pa_tick, 1);
    chk("R1 pb after reset", pb_tick, 1);
    model_on = 1;

    // R2: every fast-bus code, including codes with bit 7 clear
    for (int c = 0; c < 16; c++) measure(32'(c) << 4, "R2");

    // R3: every peripheral code for each field, fast bus at 1
    for (int c = 0; c < 8; c++) measure((32'(c) << 10) | (32'(7 - c) << 13), "R3");

    // R5: cascade with the fast bus at 4 and at 512
    for (int c = 4; c < 8; c++) measure(32'h90 | (32'(c) << 10) | (32'(c) << 13), "R5");
    measure(32'hF0 | (32'h7 << 13) | (32'h4 << 10), "R5 deep");

    // R8: readback of the fields
    wr(32'h0000_A4B0);
    @(negedge clk);
    chk("R8 readback", cfg_rdata, 32'h0000_A4B0);

    // R7: reserved bits ignored, in readback and in strobes
    wr(32'hFFFF_030F);
    @(negedge clk);
    chk("R7 reserved bits read 0", cfg_rdata, 0);
    wait_ticks(0, 3); chk("R7 hs unaffected", intv[0], 1);
    wait_ticks(2, 3); chk("R7 pb unaffected", intv[2], 1);
    wr(32'hFFFF_FFFF);
    @(negedge clk);
    chk("R7 mask on all ones", cfg_rdata, 32'h0000_FCF0);

    // R6: change the fast-bus ratio from 8 to 2 in the middle of a period
    measure(32'h0000_00A0, "R6 setup");
    wait_ticks(0, 1);
    wr(32'h0000_0080);
    wait_ticks(0, 1); chk("R6 old period kept", intv[0], 8);
    wait_ticks(0, 1); chk("R6 new period", intv[0], 2);
    wait_ticks(0, 1); chk("R6 new period steady", intv[0], 2);

    repeat (4) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule